// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block is a multi-cycle integer divider for a 32-bit processor datapath. Its dividend is 64 bits wide. The upper half comes from the Y register value and the lower half from the first operand. The divisor is the second operand. A single start pulse launches an unsigned or a signed division. Some cycles later the block presents a 32-bit quotient and an overflow flag. Quotients that do not fit in 32 bits are clamped to the nearest representable value, and the overflow flag is set.

The block never delivers a result for a zero divisor. Instead it strobes a divide-by-zero trap output and leaves its quotient and flags unchanged. The caller can also request the condition-code-updating form of the operation. In that form the N, Z, V and C flags are rewritten from the result; the plain form leaves the flags alone. The quotient comes from a restoring shift-and-subtract loop that retires one quotient bit per clock. The register width W is a parameter, 32 by default.

Top module: `wqd_divider`

## Requirements
- R1: In unsigned mode with a nonzero divisor, the quotient is floor({y_i, opa_i} / opb_i), with y_i as the upper W bits of the 2W-bit dividend, whenever that value fits in W bits, and ovf_o is 0.
- R2: A start with opb_i equal to zero raises dz_trap_o for exactly the one cycle after the accepting edge. busy_o stays low, done_o does not pulse, and quot_o, ovf_o and flags_o keep their values.
- R3: In unsigned mode, a quotient above 2^W-1 is delivered as all ones with ovf_o set.
- R4: In signed mode (two's complement operands), a quotient that fits in W signed bits is delivered truncated toward zero with ovf_o clear.
- R5: In signed mode, a negative quotient below -2^(W-1) is delivered as 1 followed by W-1 zeros, and a positive quotient above 2^(W-1)-1 is delivered as 0 followed by W-1 ones, in both cases with ovf_o set.
- R6: In signed mode, the most negative 2W-bit dividend divided by -1 is delivered as 0 followed by W-1 ones, with ovf_o set.
- R7: When setcc_i was high at the accepting edge, flags_o is rewritten as the result arrives: bit 3 N = quotient MSB, bit 2 Z = quotient is zero, bit 1 V = ovf_o, bit 0 C = 0.
- R8: When setcc_i was low at the accepting edge, flags_o is left unchanged. flags_o never changes except in a cycle where done_o is high.
- R9: start_i is accepted only while busy_o is low. busy_o is high from the accepting edge until done_o rises, 2W+1 cycles after that edge. done_o is high for exactly one cycle. A start while busy is ignored.
- R10: After reset, busy_o, done_o, dz_trap_o, ovf_o, quot_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a division (taken only when idle) |
| signed_i | input | 1 | 1 = signed two's complement, 0 = unsigned |
| setcc_i | input | 1 | 1 = rewrite flags_o with the result |
| y_i | input | W | Upper half of the dividend |
| opa_i | input | W | Lower half of the dividend |
| opb_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | W | Saturated quotient |
| ovf_o | output | 1 | Quotient was clamped |
| dz_trap_o | output | 1 | One-cycle divide-by-zero trap strobe |
| flags_o | output | 4 | Condition codes {N, Z, V, C} |

## Verification
The bench sweeps every dividend and divisor combination of a 4-bit configuration in both modes and alternates the flag-update request. This sweep reaches the clamp boundaries on both sides of the signed range, the most negative dividend over -1, and every zero divisor. A design that clamps at the wrong threshold, or that rounds negative quotients toward minus infinity, shows a wrong quotient or overflow bit on a handful of operand pairs. A design that mishandles the -1 case returns the negated dividend's low bits instead of the positive limit. A design that writes flags on plain operations or on a trap, that delivers a stale result after a zero divisor, or that takes a start while busy is caught by the flag, trap and handshake checks made after each operation.

// File: rtl/wqd_pkg.sv
package wqd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wqd_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } wqd_flags_t;

endpackage

// File: rtl/wqd_prep.sv
// Operand assembly: forms the 2W-bit dividend, strips signs in signed mode.
module wqd_prep #(
  parameter int W = 32
) (
  input  logic           signed_i,
  input  logic [W-1:0]   y_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output logic           neg_q_o,
  output logic           dvs_zero_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_raw;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    dvd_raw    = {y_i, opa_i};
    dvd_neg    = signed_i & dvd_raw[DW-1];
    dvs_neg    = signed_i & opb_i[W-1];
    dvd_mag_o  = dvd_neg ? (~dvd_raw + DW'(1)) : dvd_raw;
    dvs_mag_o  = dvs_neg ? (~opb_i + W'(1)) : opb_i;
    neg_q_o    = dvd_neg ^ dvs_neg;
    dvs_zero_o = (opb_i == '0);
  end

endmodule

// File: rtl/wqd_core.sv
// Restoring shift-subtract engine: one quotient bit per enabled clock.
module wqd_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] qmag_o
);
  localparam int DW = 2 * W;

  logic [W-1:0]  rem_q, rem_n;
  logic [DW-1:0] quo_q, quo_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    diff    = shifted - {1'b0, dvs_q};
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    if (load_i) begin
      rem_n = '0;
      quo_n = dvd_i;
      dvs_n = dvs_i;
    end else if (step_i) begin
      rem_n = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_n = {quo_q[DW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
    end
  end

  assign qmag_o = quo_q;

endmodule

// File: rtl/wqd_fix.sv
// Sign restoration and saturation of the 2W-bit quotient magnitude.
module wqd_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] qmag_i,
  input  logic           signed_i,
  input  logic           neg_i,
  output logic [W-1:0]   quot_o,
  output logic           ovf_o
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  logic hi_any;
  logic pos_big;
  logic neg_big;

  always_comb begin
    hi_any  = |qmag_i[DW-1:W];
    pos_big = hi_any | qmag_i[W-1];
    neg_big = hi_any | (qmag_i[W-1] & (|qmag_i[W-2:0]));
    quot_o  = qmag_i[W-1:0];
    ovf_o   = 1'b0;
    if (!signed_i) begin
      if (hi_any) begin
        quot_o = '1;
        ovf_o  = 1'b1;
      end
    end else if (neg_i) begin
      if (neg_big) begin
        quot_o = S_MIN;
        ovf_o  = 1'b1;
      end else begin
        quot_o = ~qmag_i[W-1:0] + W'(1);
      end
    end else if (pos_big) begin
      quot_o = S_MAX;
      ovf_o  = 1'b1;
    end
  end

endmodule

// File: rtl/wqd_divider.sv
module wqd_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         setcc_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         ovf_o,
  output logic         dz_trap_o,
  output logic [3:0]   flags_o
);
  import wqd_pkg::*;

  localparam int STEPS = 2 * W;
  localparam int CW    = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  wqd_state_e     st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           sgn_q, sgn_n;
  logic           cc_q, cc_n;
  logic           neg_q, neg_n;
  logic           trap_n;
  logic           done_n;
  logic           res_en;
  logic           mode_en;
  logic           load;
  logic           step;
  logic [W-1:0]   quot_q;
  logic           ovf_q;
  wqd_flags_t     flg_q, flg_n;
  logic           trap_q;
  logic           done_q;

  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           neg_pre;
  logic           dvs_zero;
  logic [2*W-1:0] qmag;
  logic [W-1:0]   quot_fix;
  logic           ovf_fix;

  wqd_prep #(.W(W)) u_prep (
    .signed_i  (signed_i),
    .y_i       (y_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_q_o   (neg_pre),
    .dvs_zero_o(dvs_zero)
  );

  wqd_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .step_i(step),
    .dvd_i (dvd_mag),
    .dvs_i (dvs_mag),
    .qmag_o(qmag)
  );

  wqd_fix #(.W(W)) u_fix (
    .qmag_i  (qmag),
    .signed_i(sgn_q),
    .neg_i   (neg_q),
    .quot_o  (quot_fix),
    .ovf_o   (ovf_fix)
  );

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sgn_n   = sgn_q;
    cc_n    = cc_q;
    neg_n   = neg_q;
    trap_n  = 1'b0;
    done_n  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    mode_en = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (dvs_zero) begin
            trap_n = 1'b1;
          end else begin
            load    = 1'b1;
            mode_en = 1'b1;
            sgn_n   = signed_i;
            cc_n    = setcc_i;
            neg_n   = neg_pre;
            cnt_n   = '0;
            st_n    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          st_n = ST_FIN;
        end
      end
      ST_FIN: begin
        res_en = 1'b1;
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    flg_n   = flg_q;
    if (cc_q) begin
      flg_n.n = quot_fix[W-1];
      flg_n.z = (quot_fix == '0);
      flg_n.v = ovf_fix;
      flg_n.c = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      trap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      trap_q <= trap_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_q <= 1'b0;
      cc_q  <= 1'b0;
      neg_q <= 1'b0;
    end else if (mode_en) begin
      sgn_q <= sgn_n;
      cc_q  <= cc_n;
      neg_q <= neg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      ovf_q  <= 1'b0;
      flg_q  <= '0;
    end else if (res_en) begin
      quot_q <= quot_fix;
      ovf_q  <= ovf_fix;
      flg_q  <= flg_n;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign quot_o    = quot_q;
  assign ovf_o     = ovf_q;
  assign dz_trap_o = trap_q;
  assign flags_o   = flg_q;

endmodule

// File: rtl/wqd_divider_chk.sv
module wqd_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         signed_i,
  input logic         setcc_i,
  input logic [W-1:0] opb_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quot_o,
  input logic         ovf_o,
  input logic         dz_trap_o,
  input logic [3:0]   flags_o
);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  logic sgn_seen;
  logic cc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgn_seen <= 1'b0;
      cc_seen  <= 1'b0;
    end else if (start_i && !busy_o && (opb_i != '0)) begin
      sgn_seen <= signed_i;
      cc_seen  <= setcc_i;
    end
  end

  AST_TRAP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (opb_i == '0)) |=> (dz_trap_o && !busy_o)); // R2
  AST_TRAP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap_o |-> (!done_o && $stable(quot_o) && $stable(flags_o))); // R2
  AST_UNS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o && !sgn_seen) |-> (&quot_o)); // R3
  AST_SGN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o && sgn_seen) |-> ((quot_o == S_MIN) || (quot_o == S_MAX))); // R5
  AST_FLAG_VC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cc_seen) |-> ((flags_o[1] == ovf_o) && !flags_o[0])); // R7
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o || !cc_seen) |-> $stable(flags_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R9

endmodule

bind wqd_divider wqd_divider_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .signed_i (signed_i),
  .setcc_i  (setcc_i),
  .opb_i    (opb_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .quot_o   (quot_o),
  .ovf_o    (ovf_o),
  .dz_trap_o(dz_trap_o),
  .flags_o  (flags_o)
);

// File: tb/wqd_divider_tb.sv
module wqd_divider_tb;
  localparam int W = 4;
  localparam int DW = 2 * W;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         signed_i;
  logic         setcc_i;
  logic [W-1:0] y_i;
  logic [W-1:0] opa_i;
  logic [W-1:0] opb_i;
  logic         busy_o;
  logic         done_o;
  logic [W-1:0] quot_o;
  logic         ovf_o;
  logic         dz_trap_o;
  logic [3:0]   flags_o;

  int checks;
  int errors;

  logic [W-1:0] exp_q;
  logic         exp_v;
  logic [3:0]   exp_f;

  wqd_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .setcc_i(setcc_i), .y_i(y_i), .opa_i(opa_i), .opb_i(opb_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .ovf_o(ovf_o),
    .dz_trap_o(dz_trap_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model from the requirements
  task automatic model(input int y, input int a, input int b, input bit s,
                       output logic [W-1:0] q, output logic v);
    longint dvd;
    longint dvs;
    longint r;
    dvd = longint'(y) * (longint'(1) << W) + longint'(a);
    dvs = longint'(b);
    if (s) begin
      if (dvd >= (longint'(1) << (DW - 1))) dvd = dvd - (longint'(1) << DW);
      if (dvs >= (longint'(1) << (W - 1)))  dvs = dvs - (longint'(1) << W);
    end
    r = dvd / dvs;
    v = 1'b0;
    if (!s) begin
      if (r > (longint'(1) << W) - 1) begin r = (longint'(1) << W) - 1; v = 1'b1; end
    end else begin
      if (r > (longint'(1) << (W - 1)) - 1) begin r = (longint'(1) << (W - 1)) - 1; v = 1'b1; end
      else if (r < -(longint'(1) << (W - 1))) begin r = -(longint'(1) << (W - 1)); v = 1'b1; end
    end
    q = W'(r);
  endtask

  task automatic run_op(input int y, input int a, input int b, input bit s,
                        input bit cc, input string req);
    int n;
    logic [W-1:0] mq;
    logic         mv;
    @(negedge clk);
    y_i = W'(y); opa_i = W'(a); opb_i = W'(b); signed_i = s; setcc_i = cc;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (b == 0) begin
      chk(dz_trap_o === 1'b1, "R2 trap", dz_trap_o, 1);
      chk(busy_o === 1'b0, "R2 busy", busy_o, 0);
      for (int k = 0; k < DW + 3; k++) begin
        @(negedge clk);
        if (done_o !== 1'b0 || dz_trap_o !== 1'b0)
          chk(1'b0, "R2 no done/trap repeat", {done_o, dz_trap_o}, 0);
      end
      chk(quot_o === exp_q, "R2 quot held", quot_o, exp_q);
      chk(ovf_o === exp_v, "R2 ovf held", ovf_o, exp_v);
      chk(flags_o === exp_f, "R2 flags held", flags_o, exp_f);
    end else begin
      model(y, a, b, s, mq, mv);
      n = 0;
      while (!done_o && n < 4 * DW) begin
        @(negedge clk);
        n++;
      end
      chk(n == DW + 1, "R9 latency", n, DW + 1);
      exp_q = mq;
      exp_v = mv;
      if (cc) exp_f = {mq[W-1], (mq == '0), mv, 1'b0};
      chk(quot_o === exp_q, req, quot_o, exp_q);
      chk(ovf_o === exp_v, req, ovf_o, exp_v);
      chk(flags_o === exp_f, cc ? "R7 flags" : "R8 flags kept", flags_o, exp_f);
      @(negedge clk);
      chk(done_o === 1'b0, "R9 done one cycle", done_o, 0);
      chk(busy_o === 1'b0, "R9 busy cleared", busy_o, 0);
    end
  endtask

  initial begin
    checks = 0; errors = 0;
    start_i = 1'b0; signed_i = 1'b0; setcc_i = 1'b0;
    y_i = '0; opa_i = '0; opb_i = '0;
    exp_q = '0; exp_v = 1'b0; exp_f = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk({busy_o, done_o, dz_trap_o, ovf_o} === 4'b0, "R10 control", {busy_o, done_o, dz_trap_o, ovf_o}, 0);
    chk(quot_o === '0, "R10 quot", quot_o, 0);
    chk(flags_o === 4'b0, "R10 flags", flags_o, 0);

    // R9: start while busy must be ignored
    @(negedge clk);
    y_i = 4'd0; opa_i = 4'd12; opb_i = 4'd3; signed_i = 1'b0; setcc_i = 1'b1;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R9 busy after start", busy_o, 1);
    repeat (3) @(negedge clk);
    y_i = 4'd15; opa_i = 4'd15; opb_i = 4'd1; signed_i = 1'b1; setcc_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    opb_i = 4'd0;
    while (!done_o) @(negedge clk);
    chk(quot_o === 4'd4, "R9 ignored start quot", quot_o, 4);
    exp_q = 4'd4; exp_v = 1'b0; exp_f = 4'b0000;
    chk(flags_o === exp_f, "R9 ignored start flags", flags_o, exp_f);
    @(negedge clk);
    repeat (DW + 3) begin
      @(negedge clk);
      if (busy_o !== 1'b0 || done_o !== 1'b0) chk(1'b0, "R9 no second op", busy_o, 0);
    end

    // Directed corner: most negative dividend over -1 (R6)
    run_op(8, 0, 15, 1'b1, 1'b1, "R6 min/-1");
    chk(quot_o === 4'h7 && ovf_o === 1'b1, "R6 value", {ovf_o, quot_o}, 5'h17);

    // Exhaustive sweep: R1, R3 unsigned; R4, R5 signed
    for (int s = 0; s < 2; s++)
      for (int y = 0; y < (1 << W); y++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++)
            run_op(y, a, b, s[0], ((y ^ a ^ b ^ s) & 1) == 1,
                   s == 1 ? "R4/R5 signed quotient" : "R1/R3 unsigned quotient");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule